// File: doc/BRIEF.md
# Interval-Based Output Channel Router

This unit makes the routing decision for one switch of a mesh or torus network. Every output virtual channel has three configuration values: a lower bound, an upper bound and an address mask. The destination of a packet is ANDed with the mask of each channel, and all channels then test at the same time whether the masked value lies inside their interval. The interval may wrap around the end of the address space. Channels that pass this test are called allowed.

Two further filters act on the allowed set. The first is a priority vector per channel. It lets a channel step aside whenever a channel it defers to is also allowed, which enforces an order between network dimensions. The second is a per-input bubble bit. It tells the channel whether a packet from the requesting input needs one free buffer or two.

The channels that survive both filters form a routing vector, and that vector may have several bits set. A selection stage then grants one of them. It prefers the lowest-numbered adaptive channel and falls back to the lowest-numbered escape channel. The routing vector and the grant are both registered one cycle after the request.

Top module: `ivc_router`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `route_valid`, `route_vec`, `grant_valid`, `grant_vec` and `grant_idx` are all zero. All configuration clears to zero.
- R2: A cycle with `cfg_we` high writes a field of channel `cfg_chan`. The channel index is port*NUM_VC+vc. The field is chosen by `cfg_field`: 0 lower bound, 1 upper bound, 2 mask, 3 priority vector (bit j = channel j), 4 bubble vector (bit p = input p), 5 adaptive flag (data bit 0). Codes 6 and 7 change nothing.
- R3: A channel's allowed condition uses only the destination ANDed with that channel's mask. Address bits outside the mask have no effect.
- R4: When lower ≤ upper, a channel is allowed exactly when lower ≤ masked destination ≤ upper.
- R5: When upper < lower, a channel is allowed exactly when the masked destination is ≥ lower or ≤ upper.
- R6: Suppose channel i is allowed. Its routing bit is also set only if the required buffer space is present. If bit `req_inport` of its bubble vector is 1, `free_one[i]` must be high. If that bit is 0, `free_two[i]` must be high.
- R7: Channel i is dropped from the routing vector if some channel j is allowed and bit j of channel i's priority vector is set.
- R8: A request taken with `req_valid` high at clock edge t shows up on `route_valid` and `route_vec` after edge t. After an edge without a request, `route_valid` is 0 and `route_vec`, `grant_vec` and `grant_idx` are zero.
- R9: The grant is the lowest-indexed set routing bit whose adaptive flag is 1. If there is none, the grant is the lowest-indexed set routing bit whose flag is 0. `grant_vec` is one-hot with `grant_idx` as its index, and `grant_valid` is 1.
- R10: When the routing vector is all zero, `grant_valid` is 0 and `grant_vec` is zero.
- R11: A configuration write and a request in the same cycle do not interact. The request is decided with the configuration as it stood before the write. The new value applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | CH_W | Channel to write |
| cfg_field | input | 3 | Field code to write |
| cfg_data | input | CFG_W | Write data, right-aligned |
| req_valid | input | 1 | Routing request present |
| req_dest | input | ADDR_W | Packet destination address |
| req_inport | input | IN_W | Input port the packet arrives on |
| free_one | input | CH | Per channel: at least one free buffer |
| free_two | input | CH | Per channel: at least two free buffers |
| route_valid | output | 1 | Registered result valid |
| route_vec | output | CH | Registered routing vector |
| grant_valid | output | 1 | A channel was granted |
| grant_vec | output | CH | One-hot granted channel |
| grant_idx | output | CH_W | Index of granted channel |

## Verification
The configuration write port and the request port can both be active in the same clock cycle. In that case the allowed test, the priority filter and the bubble check all read registers that are changing at that same edge. The bench provokes this by raising `cfg_we` together with `req_valid`. The write narrows a channel's upper bound so that it no longer covers the destination being requested. The bench expects the registered result of that request to still reflect the old bound. It expects a second request, one cycle later, to reflect the new bound.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [2:0] {
    FLD_LOWER  = 3'd0,
    FLD_UPPER  = 3'd1,
    FLD_MASK   = 3'd2,
    FLD_PRIO   = 3'd3,
    FLD_BUBBLE = 3'd4,
    FLD_ADAPT  = 3'd5
  } cfg_field_e;
endpackage

// File: rtl/ivc_cfg_bank.sv
module ivc_cfg_bank
  import ivc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CH     = 8,
  parameter int NUM_IN = 5,
  parameter int CH_W   = 3,
  parameter int CFG_W  = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   chan,
  input  logic [2:0]        field,
  input  logic [CFG_W-1:0]  data,
  output logic [ADDR_W-1:0] lower_o [CH],
  output logic [ADDR_W-1:0] upper_o [CH],
  output logic [ADDR_W-1:0] mask_o  [CH],
  output logic [CH-1:0]     prio_o  [CH],
  output logic [NUM_IN-1:0] bub_o   [CH],
  output logic [CH-1:0]     adapt_o
);
  logic [ADDR_W-1:0] lower_q [CH];
  logic [ADDR_W-1:0] upper_q [CH];
  logic [ADDR_W-1:0] mask_q  [CH];
  logic [CH-1:0]     prio_q  [CH];
  logic [NUM_IN-1:0] bub_q   [CH];
  logic [CH-1:0]     adapt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH; i++) begin
        lower_q[i] <= '0;
        upper_q[i] <= '0;
        mask_q[i]  <= '0;
        prio_q[i]  <= '0;
        bub_q[i]   <= '0;
      end
      adapt_q <= '0;
    end else if (we && (int'(chan) < CH)) begin
      case (field)
        FLD_LOWER:  lower_q[chan] <= data[ADDR_W-1:0];
        FLD_UPPER:  upper_q[chan] <= data[ADDR_W-1:0];
        FLD_MASK:   mask_q[chan]  <= data[ADDR_W-1:0];
        FLD_PRIO:   prio_q[chan]  <= data[CH-1:0];
        FLD_BUBBLE: bub_q[chan]   <= data[NUM_IN-1:0];
        FLD_ADAPT:  adapt_q[chan] <= data[0];
        default: ;
      endcase
    end
  end

  assign lower_o = lower_q;
  assign upper_o = upper_q;
  assign mask_o  = mask_q;
  assign prio_o  = prio_q;
  assign bub_o   = bub_q;
  assign adapt_o = adapt_q;

  AST_CFG_LOWER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && field == FLD_LOWER && int'(chan) < CH) |=> lower_q[$past(chan)] == $past(data[ADDR_W-1:0])); // R2
  AST_CFG_UPPER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && field == FLD_UPPER && int'(chan) < CH) |=> upper_q[$past(chan)] == $past(data[ADDR_W-1:0])); // R2
  AST_CFG_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(adapt_q)); // R2
endmodule

// File: rtl/ivc_lane_match.sv
module ivc_lane_match #(
  parameter int ADDR_W = 4
)(
  input  logic [ADDR_W-1:0] dest,
  input  logic [ADDR_W-1:0] lower,
  input  logic [ADDR_W-1:0] upper,
  input  logic [ADDR_W-1:0] mask,
  output logic              allowed
);
  logic [ADDR_W-1:0] masked;
  logic              ge_lo, le_hi, wraps;

  assign masked  = dest & mask;
  assign ge_lo   = (masked >= lower);
  assign le_hi   = (masked <= upper);
  assign wraps   = (upper < lower);
  assign allowed = wraps ? (ge_lo | le_hi) : (ge_lo & le_hi);
endmodule

// File: rtl/ivc_select.sv
module ivc_select #(
  parameter int CH   = 8,
  parameter int CH_W = 3
)(
  input  logic [CH-1:0]   route,
  input  logic [CH-1:0]   adapt,
  output logic            any,
  output logic [CH-1:0]   onehot,
  output logic [CH_W-1:0] idx
);
  logic            a_hit, e_hit;
  logic [CH_W-1:0] a_idx, e_idx;

  always_comb begin
    a_hit = 1'b0;
    e_hit = 1'b0;
    a_idx = '0;
    e_idx = '0;
    for (int i = CH - 1; i >= 0; i--) begin
      if (route[i] && adapt[i]) begin
        a_hit = 1'b1;
        a_idx = CH_W'(i);
      end
      if (route[i] && !adapt[i]) begin
        e_hit = 1'b1;
        e_idx = CH_W'(i);
      end
    end
  end

  assign any    = a_hit | e_hit;
  assign idx    = a_hit ? a_idx : e_idx;
  assign onehot = any ? (CH'(1) << idx) : '0;
endmodule

// File: rtl/ivc_router.sv
module ivc_router
  import ivc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_PORTS = 4,
  parameter int NUM_VC    = 2,
  parameter int NUM_IN    = 5,
  localparam int CH    = NUM_PORTS * NUM_VC,
  localparam int CH_W  = (CH > 1) ? $clog2(CH) : 1,
  localparam int IN_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CFG_W = (CH > ADDR_W) ? ((CH > NUM_IN) ? CH : NUM_IN)
                                       : ((ADDR_W > NUM_IN) ? ADDR_W : NUM_IN)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [2:0]        cfg_field,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_dest,
  input  logic [IN_W-1:0]   req_inport,
  input  logic [CH-1:0]     free_one,
  input  logic [CH-1:0]     free_two,
  output logic              route_valid,
  output logic [CH-1:0]     route_vec,
  output logic              grant_valid,
  output logic [CH-1:0]     grant_vec,
  output logic [CH_W-1:0]   grant_idx
);
  logic [ADDR_W-1:0] lower [CH];
  logic [ADDR_W-1:0] upper [CH];
  logic [ADDR_W-1:0] mask  [CH];
  logic [CH-1:0]     prio  [CH];
  logic [NUM_IN-1:0] bub   [CH];
  logic [CH-1:0]     adapt;

  logic [CH-1:0]     allowed, prio_ok, space_ok, route_c;
  logic              sel_any;
  logic [CH-1:0]     sel_vec;
  logic [CH_W-1:0]   sel_idx;

  ivc_cfg_bank #(
    .ADDR_W(ADDR_W), .CH(CH), .NUM_IN(NUM_IN), .CH_W(CH_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .chan(cfg_chan), .field(cfg_field),
    .data(cfg_data), .lower_o(lower), .upper_o(upper), .mask_o(mask),
    .prio_o(prio), .bub_o(bub), .adapt_o(adapt)
  );

  for (genvar g = 0; g < CH; g++) begin : g_lane
    logic need_one;
    ivc_lane_match #(.ADDR_W(ADDR_W)) u_match (
      .dest(req_dest), .lower(lower[g]), .upper(upper[g]),
      .mask(mask[g]), .allowed(allowed[g])
    );
    assign need_one    = (int'(req_inport) < NUM_IN) ? bub[g][req_inport] : 1'b0;
    assign prio_ok[g]  = ~|(prio[g] & allowed);
    assign space_ok[g] = need_one ? free_one[g] : free_two[g];
    assign route_c[g]  = allowed[g] & prio_ok[g] & space_ok[g];
  end

  ivc_select #(.CH(CH), .CH_W(CH_W)) u_sel (
    .route(route_c), .adapt(adapt), .any(sel_any), .onehot(sel_vec), .idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_valid <= 1'b0;
      route_vec   <= '0;
      grant_valid <= 1'b0;
      grant_vec   <= '0;
      grant_idx   <= '0;
    end else begin
      route_valid <= req_valid;
      route_vec   <= req_valid ? route_c : '0;
      grant_valid <= req_valid & sel_any;
      grant_vec   <= req_valid ? sel_vec : '0;
      grant_idx   <= req_valid ? sel_idx : '0;
    end
  end

  AST_REQ_TO_RESULT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> route_valid); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !route_valid |-> (route_vec == '0 && !grant_valid && grant_vec == '0)); // R8
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec) && (grant_valid == (grant_vec != '0))); // R9
  AST_GRANT_IN_ROUTE: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ((grant_vec & route_vec) == grant_vec)); // R9
  AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (route_valid && route_vec == '0) |-> !grant_valid); // R10
  AST_ROUTE_HAS_SPACE: assert property (@(posedge clk) disable iff (rst)
    route_valid |-> ((route_vec & ~($past(free_one) | $past(free_two))) == '0)); // R6
endmodule

// File: tb/ivc_router_bench.sv
`timescale 1ns/1ps
module ivc_router_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_chan = '0;
  logic [2:0] cfg_field = '0;
  logic [7:0] cfg_data = '0;
  logic       req_valid = 1'b0;
  logic [3:0] req_dest = '0;
  logic [2:0] req_inport = '0;
  logic [7:0] free_one = '0;
  logic [7:0] free_two = '0;
  logic       route_valid, grant_valid;
  logic [7:0] route_vec, grant_vec;
  logic [2:0] grant_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [3:0] m_lo [8];
  logic [3:0] m_hi [8];
  logic [3:0] m_mk [8];
  logic [7:0] m_pr [8];
  logic [4:0] m_bb [8];
  logic [7:0] m_ad;

  ivc_router u_ivc_router (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_dest(req_dest), .req_inport(req_inport), .free_one(free_one),
    .free_two(free_two), .route_valid(route_valid), .route_vec(route_vec),
    .grant_valid(grant_valid), .grant_vec(grant_vec), .grant_idx(grant_idx)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_allowed(input logic [3:0] d);
    logic [7:0] a;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] md;
      md = d & m_mk[i];
      if (m_lo[i] <= m_hi[i]) a[i] = (md >= m_lo[i]) && (md <= m_hi[i]);
      else                    a[i] = (md >= m_lo[i]) || (md <= m_hi[i]);
    end
    return a;
  endfunction

  function automatic logic [7:0] f_route(input logic [3:0] d, input int p);
    logic [7:0] a, r;
    a = f_allowed(d);
    for (int i = 0; i < 8; i++)
      r[i] = a[i] && ((m_pr[i] & a) == 0) && (m_bb[i][p] ? free_one[i] : free_two[i]);
    return r;
  endfunction

  function automatic int f_grant(input logic [7:0] r);
    for (int i = 0; i < 8; i++) if (r[i] && m_ad[i]) return i;
    for (int i = 0; i < 8; i++) if (r[i] && !m_ad[i]) return i;
    return -1;
  endfunction

  task automatic model_write(input int ch, input int fld, input logic [7:0] d);
    case (fld)
      0: m_lo[ch] = d[3:0];
      1: m_hi[ch] = d[3:0];
      2: m_mk[ch] = d[3:0];
      3: m_pr[ch] = d;
      4: m_bb[ch] = d[4:0];
      5: m_ad[ch] = d[0];
      default: ;
    endcase
  endtask

  task automatic wr(input int ch, input int fld, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 3'(ch); cfg_field = 3'(fld); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(ch, fld, d);
  endtask

  task automatic chan_cfg(input int ch, input logic [3:0] lo, input logic [3:0] hi,
                          input logic [3:0] mk, input logic [7:0] pr,
                          input logic [4:0] bb, input bit ad);
    wr(ch, 0, 8'(lo)); wr(ch, 1, 8'(hi)); wr(ch, 2, 8'(mk));
    wr(ch, 3, pr); wr(ch, 4, 8'(bb)); wr(ch, 5, 8'(ad));
  endtask

  task automatic compare(input logic [7:0] er, input string tag);
    int g;
    g = f_grant(er);
    check(route_valid === 1'b1 && route_vec === er, tag, route_vec, er);
    if (g < 0)
      check(grant_valid === 1'b0 && grant_vec === 8'h00, "R10 no grant", grant_vec, 0);
    else
      check(grant_valid === 1'b1 && grant_vec === (8'h01 << g) && grant_idx === 3'(g),
            "R9 selection", {grant_idx, grant_vec}, {3'(g), 8'h01 << g});
  endtask

  task automatic req(input logic [3:0] d, input int p, input string tag);
    logic [7:0] er;
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; req_inport = 3'(p);
    er = f_route(d, p);
    @(negedge clk);
    req_valid = 1'b0;
    compare(er, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_mk[i] = 0; m_pr[i] = 0; m_bb[i] = 0;
    end
    m_ad = 0;
    repeat (3) @(negedge clk);
    check(route_valid === 0 && route_vec === 0 && grant_valid === 0 && grant_vec === 0,
          "R1 during reset", {route_valid, route_vec}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(route_valid === 0 && route_vec === 0 && grant_valid === 0 && grant_idx === 0,
          "R1 after reset", {route_valid, route_vec}, 0);
    // R1 config cleared: all-zero bounds and mask allow every channel, free_two=0 blocks all.
    free_one = 8'hFF; free_two = 8'h00;
    req(4'd9, 0, "R1 cleared config");

    // R3 R4 R5: mixed bounds, masks and wrapping intervals.
    chan_cfg(0, 4'd2,  4'd5,  4'hF, 8'h00, 5'h1F, 0);
    chan_cfg(1, 4'd12, 4'd3,  4'hF, 8'h00, 5'h1F, 1);
    chan_cfg(2, 4'd0,  4'd1,  4'h3, 8'h00, 5'h1F, 0);
    chan_cfg(3, 4'd4,  4'd8,  4'hC, 8'h00, 5'h1F, 1);
    chan_cfg(4, 4'd7,  4'd7,  4'hF, 8'h00, 5'h1F, 0);
    chan_cfg(5, 4'd15, 4'd0,  4'hF, 8'h00, 5'h1F, 1);
    chan_cfg(6, 4'd9,  4'd6,  4'hF, 8'h00, 5'h1F, 0);
    chan_cfg(7, 4'd14, 4'd14, 4'hF, 8'h00, 5'h1F, 1);
    for (int d = 0; d < 16; d++)
      for (int p = 0; p < 5; p++)
        req(4'(d), p, "R3 R4 R5 interval sweep");
    // R8: idle cycle after a request.
    @(negedge clk);
    check(route_valid === 0 && route_vec === 0 && grant_vec === 0 && grant_idx === 0,
          "R8 idle clears", route_vec, 0);

    // R2: field codes 6 and 7 change nothing.
    wr(0, 6, 8'h00); wr(0, 7, 8'hFF);
    req(4'd3, 0, "R2 unused field codes");

    // R6: bubble bits against buffer-space patterns.
    for (int i = 0; i < 8; i++) wr(i, 4, 8'(5'(i * 3 + 1)));
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: begin free_one = 8'hFF; free_two = 8'h00; end
        1: begin free_one = 8'hFF; free_two = 8'hFF; end
        2: begin free_one = 8'h0F; free_two = 8'hF0; end
        3: begin free_one = 8'hAA; free_two = 8'h55; end
        default: begin free_one = 8'h00; free_two = 8'h00; end
      endcase
      for (int p = 0; p < 5; p++)
        for (int d = 0; d < 16; d += 5)
          req(4'(d), p, "R6 bubble space");
    end

    // R7: dimension-ordered mesh, node x=1 y=1; 0,1 X+; 2,3 X-; 4,5 Y+; 6,7 Y-.
    free_one = 8'hFF; free_two = 8'h00;
    chan_cfg(0, 4'd2, 4'd3,  4'h3, 8'h00, 5'h1F, 0);
    chan_cfg(1, 4'd2, 4'd3,  4'h3, 8'h00, 5'h1F, 0);
    chan_cfg(2, 4'd0, 4'd0,  4'h3, 8'h00, 5'h1F, 0);
    chan_cfg(3, 4'd0, 4'd0,  4'h3, 8'h00, 5'h1F, 0);
    chan_cfg(4, 4'd8, 4'd12, 4'hC, 8'h0F, 5'h1F, 0);
    chan_cfg(5, 4'd8, 4'd12, 4'hC, 8'h0F, 5'h1F, 0);
    chan_cfg(6, 4'd0, 4'd0,  4'hC, 8'h0F, 5'h1F, 0);
    chan_cfg(7, 4'd0, 4'd0,  4'hC, 8'h0F, 5'h1F, 0);
    for (int d = 0; d < 16; d++) req(4'(d), 0, "R7 priority sweep");
    @(negedge clk); req_valid = 1; req_dest = 4'd10; req_inport = 0;
    @(negedge clk); req_valid = 0;
    check(route_vec === 8'h03 && grant_idx === 3'd0, "R7 X before Y", route_vec, 8'h03);
    @(negedge clk); req_valid = 1; req_dest = 4'd9; req_inport = 0;
    @(negedge clk); req_valid = 0;
    check(route_vec === 8'h30 && grant_idx === 3'd4, "R7 Y when X done", route_vec, 8'h30);
    @(negedge clk); req_valid = 1; req_dest = 4'd5; req_inport = 0;
    @(negedge clk); req_valid = 0;
    check(route_vec === 8'h00 && grant_valid === 0, "R10 local node", route_vec, 0);
    // R9: adaptive preferred over lower-index escape.
    wr(1, 5, 8'h01);
    @(negedge clk); req_valid = 1; req_dest = 4'd10; req_inport = 0;
    @(negedge clk); req_valid = 0;
    check(grant_idx === 3'd1 && grant_vec === 8'h02, "R9 adaptive first", grant_idx, 1);

    // R11: write upper bound and request in the same cycle.
    @(negedge clk);
    cfg_we = 1; cfg_chan = 3'd0; cfg_field = 3'd1; cfg_data = 8'd2;
    req_valid = 1; req_dest = 4'd3; req_inport = 0;
    begin
      logic [7:0] er;
      er = f_route(4'd3, 0);
      @(negedge clk);
      cfg_we = 0; req_valid = 0;
      check(route_vec === er, "R11 old config used", route_vec, er);
    end
    model_write(0, 1, 8'd2);
    req(4'd3, 0, "R11 new config applied");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule